// File: doc/BRIEF.md
# Autoranging Event Capture Buffer

This block sits behind a free-running 12-bit ADC that samples one of several gain paths through an analogue multiplexer. It watches a signal-over-threshold flag (`sot`) and a 3-bit classification code, drives the multiplexer select from that code on the same cycle, and stores only the samples taken while `sot` is high. Because the select follows the live code, the gain range can change in the middle of an event. Each stored sample therefore carries the range it was taken in.

Every accepted event starts with one header word. The header holds the classification code at the rising edge of `sot` and a 32-bit count of clock cycles (5 ns per cycle at the ADC rate). Words go into an on-chip ring buffer and leave through a valid/ready stream. The producer side has no back-pressure: the ADC never stops. When the buffer has too little space, whole events are dropped and counted. Samples that arrive once the buffer is full are discarded. Independently of storage, a rate monitor counts `sot` rising edges over a programmable gate window, so an event rate remains available while the buffer is full.

Stream rules: a word moves on every rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `out_ready` may be held low for any length of time. Capture continues meanwhile, and overflow is handled as described in R6 and R7.

Top module: `evcap_buffer`

## Requirements
- R1: `range_sel` is decoded combinationally from `cls` as a thermometer code: 000→0 (x1 path), 001→1 (/8), 011→2 (/64), 111→3 (integrator). Any other pattern saturates to the highest set bit: 010→2, 100/101/110→3.
- R2: No word is written for any cycle in which `sot` is low; an idle input leaves the stream empty.
- R3: At a cycle where `sot` is high after being low, if at least 2 entries are free, a header word is written: bit 35 = 1, bits 34:32 = `cls` of that cycle, bits 31:0 = timestamp. The timestamp is the number of clock edges since reset release, counting from 0 at the first edge.
- R4: Every cycle of an accepted event with `sot` high writes one sample word after the header, in arrival order: bit 35 = 0, bits 13:12 = range of that cycle (per R1), bits 11:0 = ADC sample, and all other bits 0.
- R5: The range tag follows `cls` cycle by cycle inside one event, so a single event can hold samples of different ranges.
- R6: If fewer than 2 entries are free at the rising edge of `sot`, no word of that event is written and `drop_count` increases by one.
- R7: When the buffer holds DEPTH words, further samples of the running event are discarded; `buf_full` is high exactly while DEPTH words are held.
- R8: `out_valid` is high whenever the buffer is non-empty; words leave in write order; `out_data` is stable while stalled.
- R9: `rate_count` is loaded, at the end of every window of max(`rate_window`,1) cycles, with the number of `sot` rising edges in that window, accepted or dropped. `rate_valid` pulses for one cycle at each load.
- R10: After reset the stream is empty, and `buf_full`, `drop_count`, `rate_count` and `rate_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_sample | input | 12 | ADC sample, one per cycle |
| sot | input | 1 | Signal over threshold |
| cls | input | 3 | Classification code |
| range_sel | output | 2 | Gain path select for the multiplexer |
| rate_window | input | RATE_W | Gate window length in cycles |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Stream consumer accepts |
| out_data | output | 36 | Stream word (header or sample) |
| buf_full | output | 1 | Buffer holds DEPTH words |
| drop_count | output | DROP_W | Events dropped for lack of space |
| rate_count | output | RATE_W | Rising edges in last gate window |
| rate_valid | output | 1 | One-cycle pulse when `rate_count` loads |

## Verification
Two functions often fall on the same clock edge. First, a buffer write (header or sample) can coincide with a stream read. Near the fill limit this decides whether an event is admitted, because admission looks at the occupancy before that edge's read. Second, the end of a rate window can coincide with a `sot` rising edge, which must count in the closing window. Random `sot` runs and a 60 % random `out_ready` against a small buffer provoke both often. A bench model that replays the occupancy and window rules judges each edge, comparing every drained word, `drop_count` and `rate_count`.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int SAMPLE_W = 12;
  localparam int CLS_W    = 3;
  localparam int RNG_W    = $clog2(CLS_W + 1);
  localparam int TS_W     = 32;
  localparam int WORD_W   = 1 + CLS_W + TS_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_header(logic [CLS_W-1:0] c, logic [TS_W-1:0] t);
    return {1'b1, c, t};
  endfunction

  function automatic word_t pack_sample(logic [RNG_W-1:0] r, logic [SAMPLE_W-1:0] s);
    word_t w;
    w = '0;
    w[SAMPLE_W +: RNG_W] = r;
    w[SAMPLE_W-1:0]      = s;
    return w;
  endfunction
endpackage

// File: rtl/evcap_range_decode.sv
module evcap_range_decode #(
  parameter int N  = 3,
  parameter int RW = $clog2(N + 1)
) (
  input  logic [N-1:0]  cls,
  output logic [RW-1:0] rng
);
  // highest set bit wins: valid thermometer codes map to their length
  always_comb begin
    rng = '0;
    for (int i = 0; i < N; i++) begin
      if (cls[i]) rng = RW'(i + 1);
    end
  end
endmodule

// File: rtl/evcap_ring.sv
module evcap_ring #(
  parameter int DEPTH = 448,
  parameter int W     = 36,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             rd_fire;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign out_data  = mem[rd_ptr];
  assign rd_fire   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en)   wr_ptr <= bump(wr_ptr);
      if (rd_fire) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CNT_W'(DEPTH)));

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/evcap_writer.sv
module evcap_writer
  import evcap_pkg::*;
#(
  parameter int DEPTH  = 448,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int DROP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sot,
  input  logic [CLS_W-1:0]    cls,
  input  logic [RNG_W-1:0]    rng,
  input  logic [SAMPLE_W-1:0] adc,
  input  logic [CNT_W-1:0]    count,
  output logic                wr_en,
  output word_t               wr_data,
  output logic                sot_rise,
  output logic [DROP_W-1:0]   drop_count
);
  localparam int HDR_PLUS_ONE = 2;

  logic                p_sot;
  logic [RNG_W-1:0]    p_rng;
  logic [SAMPLE_W-1:0] p_adc;
  logic                accepted;
  logic [TS_W-1:0]     ts;
  logic                room, wr_hdr, wr_smp;

  assign sot_rise = sot && !p_sot;
  assign room     = (count <= CNT_W'(DEPTH - HDR_PLUS_ONE));
  assign wr_hdr   = sot_rise && room;
  // samples are delayed one cycle so the header owns the rising-edge slot
  assign wr_smp   = p_sot && accepted && (count < CNT_W'(DEPTH));
  assign wr_en    = wr_hdr || wr_smp;
  assign wr_data  = wr_hdr ? pack_header(cls, ts) : pack_sample(p_rng, p_adc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_sot      <= 1'b0;
      p_rng      <= '0;
      p_adc      <= '0;
      accepted   <= 1'b0;
      ts         <= '0;
      drop_count <= '0;
    end else begin
      p_sot <= sot;
      p_rng <= rng;
      p_adc <= adc;
      ts    <= ts + 1'b1;
      if (sot_rise) begin
        accepted <= room;
        if (!room) drop_count <= drop_count + 1'b1;
      end
    end
  end

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!sot && !p_sot) |-> !wr_en);

  a_r6_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_rise && (count > CNT_W'(DEPTH - HDR_PLUS_ONE))) |=>
      (drop_count == $past(drop_count) + 1'b1));

  a_r3_header_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[WORD_W-1]) |-> sot_rise);
endmodule

// File: rtl/evcap_rate.sv
module evcap_rate #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         event_pulse,
  input  logic [W-1:0] window,
  output logic [W-1:0] rate_count,
  output logic         rate_valid
);
  logic [W-1:0] win_cnt, acc;
  logic         last;

  assign last = ({1'b0, win_cnt} + 1'b1) >= {1'b0, window};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      acc        <= '0;
      rate_count <= '0;
      rate_valid <= 1'b0;
    end else if (last) begin
      win_cnt    <= '0;
      acc        <= '0;
      rate_count <= acc + W'(event_pulse);
      rate_valid <= 1'b1;
    end else begin
      win_cnt    <= win_cnt + 1'b1;
      acc        <= acc + W'(event_pulse);
      rate_valid <= 1'b0;
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid && (window > W'(1)) && $stable(window)) |=> !rate_valid);

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid && $stable(window)) |-> ({1'b0, rate_count} <= {1'b0, window} + 1'b1));
endmodule

// File: rtl/evcap_buffer.sv
module evcap_buffer
  import evcap_pkg::*;
#(
  parameter int DEPTH  = 448,
  parameter int RATE_W = 24,
  parameter int DROP_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic                sot,
  input  logic [CLS_W-1:0]    cls,
  output logic [RNG_W-1:0]    range_sel,
  input  logic [RATE_W-1:0]   rate_window,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic                buf_full,
  output logic [DROP_W-1:0]   drop_count,
  output logic [RATE_W-1:0]   rate_count,
  output logic                rate_valid
);
  logic             wr_en, sot_rise;
  word_t            wr_data;
  logic [CNT_W-1:0] count;

  evcap_range_decode #(.N(CLS_W), .RW(RNG_W)) u_decode (
    .cls (cls),
    .rng (range_sel)
  );

  a_r1_thermo_011: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 3'b011) |-> (range_sel == 2'd2));
  a_r1_thermo_000: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 3'b000) |-> (range_sel == 2'd0));

  evcap_writer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sot        (sot),
    .cls        (cls),
    .rng        (range_sel),
    .adc        (adc_sample),
    .count      (count),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .sot_rise   (sot_rise),
    .drop_count (drop_count)
  );

  evcap_ring #(.DEPTH(DEPTH), .W(WORD_W), .CNT_W(CNT_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .count     (count),
    .full      (buf_full)
  );

  evcap_rate #(.W(RATE_W)) u_rate (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_pulse (sot_rise),
    .window      (rate_window),
    .rate_count  (rate_count),
    .rate_valid  (rate_valid)
  );

  a_r10_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !buf_full && !rate_valid));
endmodule

// File: tb/evcap_buffer_bench.sv
module evcap_buffer_bench;
  localparam int DEPTH  = 24;
  localparam int RATE_W = 16;
  localparam int DROP_W = 16;
  localparam int WIN    = 37;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [11:0]       adc_sample;
  logic              sot;
  logic [2:0]        cls;
  logic [1:0]        range_sel;
  logic [RATE_W-1:0] rate_window;
  logic              out_valid, out_ready;
  logic [35:0]       out_data;
  logic              buf_full;
  logic [DROP_W-1:0] drop_count;
  logic [RATE_W-1:0] rate_count;
  logic              rate_valid;

  evcap_buffer #(.DEPTH(DEPTH), .RATE_W(RATE_W), .DROP_W(DROP_W)) u_evcap_buffer (
    .clk(clk), .rst_n(rst_n), .adc_sample(adc_sample), .sot(sot), .cls(cls),
    .range_sel(range_sel), .rate_window(rate_window), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .buf_full(buf_full),
    .drop_count(drop_count), .rate_count(rate_count), .rate_valid(rate_valid)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [35:0] q[$];
  logic [35:0] seen[$];
  logic        m_psot = 0, m_on = 0;
  logic [1:0]  m_prng = 0;
  logic [11:0] m_padc = 0;
  logic [31:0] m_ts = 0;
  int unsigned m_drop = 0, m_win = 0, m_acc = 0, m_rate = 0;
  bit          m_rv = 0;
  int          rdy_mode = 0;
  bit          prev_stall = 0;
  logic [35:0] prev_data = '0;

  function automatic logic [1:0] exp_range(logic [2:0] c);
    case (c)
      3'b000: return 2'd0;
      3'b001: return 2'd1;
      3'b010: return 2'd2;
      3'b011: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [35:0] mk_header(logic [2:0] c, logic [31:0] t);
    return {1'b1, c, t};
  endfunction

  function automatic logic [35:0] mk_sample(logic [1:0] r, logic [11:0] s);
    return {1'b0, 21'd0, r, s};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [2:0] c, input logic [11:0] a);
    bit rise, xfer;
    int unsigned cnt;
    logic [1:0] r;
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (($urandom % 10) < 6);
    endcase
    chk(out_valid == (q.size() != 0), "R8", out_valid, q.size() != 0, "out_valid");
    chk(buf_full == (q.size() == DEPTH), "R7", buf_full, q.size() == DEPTH, "buf_full");
    chk(drop_count == m_drop, "R6", drop_count, m_drop, "drop_count");
    chk(rate_count == m_rate, "R9", rate_count, m_rate, "rate_count");
    chk(rate_valid == m_rv, "R9", rate_valid, m_rv, "rate_valid");
    if (prev_stall) chk(out_data == prev_data, "R8", out_data, prev_data, "stalled data");
    xfer = out_valid && out_ready && (q.size() != 0);
    if (xfer) begin
      chk(out_data == q[0], q[0][35] ? "R3" : "R4", out_data, q[0], "stream word");
      seen.push_back(out_data);
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    sot = s; cls = c; adc_sample = a;
    #1;
    r = exp_range(c);
    chk(range_sel == r, "R1", range_sel, r, "range_sel");
    // model of the coming edge
    cnt  = q.size();
    rise = s && !m_psot;
    if (xfer) void'(q.pop_front());
    if (rise) begin
      if (cnt <= DEPTH - 2) begin
        q.push_back(mk_header(c, m_ts));
        m_on = 1;
      end else begin
        m_on = 0;
        m_drop++;
      end
    end else if (m_psot && m_on && cnt < DEPTH) begin
      q.push_back(mk_sample(m_prng, m_padc));
    end
    if (m_win + 1 >= WIN) begin
      m_rate = m_acc + rise; m_acc = 0; m_win = 0; m_rv = 1;
    end else begin
      m_acc += rise; m_win++; m_rv = 0;
    end
    m_psot = s; m_prng = r; m_padc = a; m_ts++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    rdy_mode = 1;
    for (int i = 0; i < 4 * DEPTH && q.size() != 0; i++) step(1'b0, 3'b000, 12'h000);
    step(1'b0, 3'b000, 12'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic s;
    void'($urandom(32'd20240611));
    rst_n = 0; sot = 0; cls = 0; adc_sample = 0; out_ready = 0; rate_window = WIN;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!out_valid, "R10", out_valid, 0, "out_valid in reset");
    chk(!buf_full, "R10", buf_full, 0, "buf_full in reset");
    chk(drop_count == 0, "R10", drop_count, 0, "drop_count in reset");
    chk(rate_count == 0 && !rate_valid, "R10", {rate_count, rate_valid}, 0, "rate in reset");
    rst_n = 1;

    // R5: range changes within one event
    rdy_mode = 0;
    step(0, 3'b000, 12'h000);
    step(1, 3'b000, 12'h111);
    step(1, 3'b001, 12'h222);
    step(1, 3'b011, 12'h333);
    step(1, 3'b111, 12'h444);
    step(0, 3'b000, 12'h000);
    seen.delete();
    drain();
    chk(seen.size() == 5, "R5", seen.size(), 5, "words of event");
    if (seen.size() == 5) begin
      chk(seen[0][35:32] == 4'b1000, "R3", seen[0][35:32], 4'b1000, "header kind and class");
      for (int k = 1; k < 5; k++)
        chk(seen[k][13:12] == 2'(k - 1), "R5", seen[k][13:12], k - 1, "range tag");
      chk(seen[4][11:0] == 12'h444, "R4", seen[4][11:0], 12'h444, "last sample");
    end

    // R2: idle input leaves the stream empty
    for (int i = 0; i < 12; i++) step(0, 3'($urandom), 12'($urandom));
    chk(!out_valid, "R2", out_valid, 0, "idle stream");

    // R7 truncation then R6 drop
    rdy_mode = 0;
    for (int i = 0; i < DEPTH + 5; i++) step(1, 3'($urandom), 12'($urandom));
    step(0, 3'b000, 12'h000);
    chk(buf_full, "R7", buf_full, 1, "full after long event");
    step(1, 3'b001, 12'h055);
    step(0, 3'b000, 12'h000);
    chk(drop_count == 1, "R6", drop_count, 1, "event dropped when full");
    drain();

    // constrained random traffic
    s = 0;
    for (int i = 0; i < 4000; i++) begin
      rdy_mode = 2;
      if (($urandom % 6) == 0) s = !s;
      step(s, 3'($urandom), 12'($urandom));
    end
    drain();
    chk(!out_valid, "R8", out_valid, 0, "empty after drain");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule